// File: doc/BRIEF.md
# Swapped-Context Multi-Channel DMA Controller

This block serves several logical DMA channels with one shared transfer engine. The state of each channel lives in a small context RAM: a source address, a destination address, a remaining byte count and a link to a follow-on descriptor. The CPU fills entries through a write port. Each channel has a level-sensitive request line. A round-robin arbiter picks a requesting channel, and the engine reads that channel's context out of the RAM. The engine then copies a bounded burst of 32-bit words over a simple request/acknowledge memory bus and writes the advanced context back. Only then can another channel be swapped in.

When a channel's count runs out, the engine looks at the link. A nonzero link makes the engine read a fresh four-word descriptor from memory, and the channel carries on during later activations. A zero link ends the channel and raises its done pulse. Long transfers are split over several activations, so no channel can hold the engine for longer than one burst.

Top module: `dma_swap_top`

## Requirements
- R1: At most one channel is held in the engine at a time. After a channel is granted, its RAM entry is read, and that read takes one cycle of latency. The first memory request of the activation is raised no earlier than two cycles after the grant.
- R2: Each context entry holds four fields: source address, destination address, remaining byte count and descriptor link. A CPU write sets all four fields of the entry selected by the channel index.
- R3: Each moved word is read from the current source address and then written to the current destination address. After the write is acknowledged, both addresses advance by 4 and the count drops by 4. Counts are multiples of 4.
- R4: One activation moves at most BURST words (default 4). The engine then writes the context back and arbitrates again, even if bytes remain.
- R5: Requesting channels are served round-robin by index, starting from the index after the channel served last. After reset, the search starts at channel 0.
- R6: When the count reaches zero and the link is nonzero, the engine reads words at link+0, link+4, link+8 and link+12. These become the new source, destination, count and link, in that order. It then writes this new context back without a done pulse.
- R7: When the count reaches zero and the link is zero, the channel's bit of ch_done_o pulses high for exactly one cycle after the write-back. At most one done bit is high in any cycle.
- R8: cpu_wr_ready_o is low while cpu_ch_i names the channel that is loaded or about to be loaded. It is also low during an engine write-back. A write aimed at any other channel is accepted.
- R9: A channel loaded with a zero count makes no memory request and raises no done pulse.
- R10: Once mem_req_o is raised, it stays high with a stable address and write flag until mem_ack_i is seen.
- R11: After reset, mem_req_o and ch_done_o are low and cpu_wr_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chan_req_i | input | NCH | Per-channel service request, level |
| cpu_wr_valid_i | input | 1 | CPU context write strobe |
| cpu_wr_ready_o | output | 1 | Context write can be taken this cycle |
| cpu_ch_i | input | CHW | Channel index of the context write |
| cpu_src_i | input | AW | Source address to store |
| cpu_dst_i | input | AW | Destination address to store |
| cpu_cnt_i | input | CW | Byte count to store |
| cpu_ptr_i | input | AW | Descriptor link to store (0 = none) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Access completed |
| ch_done_o | output | NCH | One-cycle end-of-channel pulses |

## Verification
The case hardest to reach from the ports is the CPU write lock. It only shows while a particular channel's context sits inside the engine, and that window lasts just a few bus cycles. The bench gives one channel a long transfer. It watches the bus until addresses from that channel's source range appear, then presents that channel's index and a different index on the CPU port. It checks that ready is low for the first and high for the second. Interleaving under round-robin is reached by raising three requests in the same cycle. Each channel's transfer is sized above the burst limit, and the recorded order of write addresses must alternate in bursts of BURST.

// File: rtl/dma_swap_pkg.sv
package dma_swap_pkg;
    localparam int AW = 16;   // byte address width
    localparam int CW = 16;   // byte count width
    localparam int DW = 32;   // bus word width

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [AW-1:0] ptr;
    } chan_ctx_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_RD, S_WR, S_FETCH, S_WB
    } eng_st_e;
endpackage

// File: rtl/dma_ctx_ram.sv
module dma_ctx_ram
    import dma_swap_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           rd_en_i,
    input  logic [CHW-1:0] rd_idx_i,
    output chan_ctx_t      rd_data_o,
    input  logic           wr_en_i,
    input  logic [CHW-1:0] wr_idx_i,
    input  chan_ctx_t      wr_data_i
);
    chan_ctx_t mem_q [NCH];
    chan_ctx_t rd_q;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    end

    // registered read port: one cycle of latency
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= mem_q[rd_idx_i];
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] req_i,
    input  logic           take_i,
    output logic           any_o,
    output logic [CHW-1:0] pick_o
);
    logic [CHW-1:0] last_d, last_q;
    logic           found;
    int             j;

    always_comb begin
        found  = 1'b0;
        pick_o = '0;
        j      = 0;
        for (int k = 1; k <= NCH; k++) begin
            j = (int'(last_q) + k) % NCH;
            if (!found && req_i[j]) begin
                found  = 1'b1;
                pick_o = CHW'(j);
            end
        end
        any_o  = found;
        last_d = take_i ? pick_o : last_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= CHW'(NCH - 1);
        else         last_q <= last_d;
    end

    a_r5_pick_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_o |-> req_i[pick_o]);
    a_r5_moves_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> (last_q == $past(pick_o)));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_swap_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int BURST = 4,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BW   = $clog2(BURST + 1)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           req_any_i,
    input  logic [CHW-1:0] pick_i,
    output logic           take_o,
    output logic           ram_rd_en_o,
    output logic [CHW-1:0] ram_rd_idx_o,
    input  chan_ctx_t      ram_rd_data_i,
    output logic           ram_wr_en_o,
    output logic [CHW-1:0] ram_wr_idx_o,
    output chan_ctx_t      ram_wr_data_o,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ack_i,
    output logic [NCH-1:0] done_o,
    output logic           busy_o,
    output logic [CHW-1:0] act_ch_o
);
    typedef struct packed {
        eng_st_e        st;
        logic [CHW-1:0] ch;
        chan_ctx_t      ctx;
        chan_ctx_t      fet;
        logic [1:0]     fidx;
        logic [BW-1:0]  beats;
        logic [DW-1:0]  hold;
        logic           fin;
        logic [NCH-1:0] done;
    } eng_t;

    eng_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.done      = '0;
        take_o        = 1'b0;
        ram_rd_en_o   = 1'b0;
        ram_rd_idx_o  = pick_i;
        ram_wr_en_o   = 1'b0;
        ram_wr_idx_o  = r_q.ch;
        ram_wr_data_o = r_q.ctx;
        mem_req_o     = 1'b0;
        mem_we_o      = 1'b0;
        mem_addr_o    = r_q.ctx.src;
        mem_wdata_o   = r_q.hold;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_any_i) begin
                    take_o      = 1'b1;
                    ram_rd_en_o = 1'b1;
                    r_d.ch      = pick_i;
                    r_d.st      = S_LOAD;
                end
            end
            S_LOAD: begin
                // RAM data is valid now, one cycle after the read was issued
                r_d.ctx   = ram_rd_data_i;
                r_d.beats = '0;
                r_d.fin   = 1'b0;
                r_d.st    = (ram_rd_data_i.cnt == '0) ? S_WB : S_RD;
            end
            S_RD: begin
                mem_req_o = 1'b1;
                if (mem_ack_i) begin
                    r_d.hold = mem_rdata_i;
                    r_d.st   = S_WR;
                end
            end
            S_WR: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = r_q.ctx.dst;
                if (mem_ack_i) begin
                    r_d.ctx.src = r_q.ctx.src + AW'(4);
                    r_d.ctx.dst = r_q.ctx.dst + AW'(4);
                    r_d.ctx.cnt = r_q.ctx.cnt - CW'(4);
                    r_d.beats   = r_q.beats + 1'b1;
                    if (r_q.ctx.cnt == CW'(4)) begin
                        if (r_q.ctx.ptr != '0) begin
                            r_d.fidx = '0;
                            r_d.st   = S_FETCH;
                        end else begin
                            r_d.fin = 1'b1;
                            r_d.st  = S_WB;
                        end
                    end else if (r_q.beats == BW'(BURST - 1)) begin
                        r_d.st = S_WB;
                    end else begin
                        r_d.st = S_RD;
                    end
                end
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.ctx.ptr + AW'({r_q.fidx, 2'b00});
                if (mem_ack_i) begin
                    r_d.fidx = r_q.fidx + 1'b1;
                    unique case (r_q.fidx)
                        2'd0: r_d.fet.src = mem_rdata_i[AW-1:0];
                        2'd1: r_d.fet.dst = mem_rdata_i[AW-1:0];
                        2'd2: r_d.fet.cnt = mem_rdata_i[CW-1:0];
                        default: begin
                            r_d.ctx.src = r_q.fet.src;
                            r_d.ctx.dst = r_q.fet.dst;
                            r_d.ctx.cnt = r_q.fet.cnt;
                            r_d.ctx.ptr = mem_rdata_i[AW-1:0];
                            r_d.st      = S_WB;
                        end
                    endcase
                end
            end
            S_WB: begin
                ram_wr_en_o = 1'b1;
                if (r_q.fin) r_d.done[r_q.ch] = 1'b1;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o   = r_q.done;
    assign busy_o   = (r_q.st != S_IDLE);
    assign act_ch_o = r_q.ch;

    a_r1_load_before_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_req_o) |-> ($past(r_q.st) != S_IDLE));
    a_r4_burst_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.beats <= BW'(BURST));
    a_r7_done_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(done_o));
    a_r7_done_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o != '0) |-> ($past(ram_wr_en_o) && done_o[$past(ram_wr_idx_o)]));
    a_r10_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/dma_swap_top.sv
module dma_swap_top
    import dma_swap_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int BURST = 4,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] chan_req_i,
    input  logic           cpu_wr_valid_i,
    output logic           cpu_wr_ready_o,
    input  logic [CHW-1:0] cpu_ch_i,
    input  logic [AW-1:0]  cpu_src_i,
    input  logic [AW-1:0]  cpu_dst_i,
    input  logic [CW-1:0]  cpu_cnt_i,
    input  logic [AW-1:0]  cpu_ptr_i,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ack_i,
    output logic [NCH-1:0] ch_done_o
);
    logic           req_any, take, busy;
    logic [CHW-1:0] pick, act_ch, lock_ch;
    logic           rd_en, eng_we, ram_we;
    logic [CHW-1:0] rd_idx, eng_widx, ram_widx;
    chan_ctx_t      rd_data, eng_wdata, ram_wdata, cpu_ctx;

    dma_rr_arb #(.NCH(NCH)) i_arb (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(chan_req_i),
        .take_i(take), .any_o(req_any), .pick_o(pick)
    );

    dma_engine #(.NCH(NCH), .BURST(BURST)) i_eng (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_any_i(req_any), .pick_i(pick),
        .take_o(take), .ram_rd_en_o(rd_en), .ram_rd_idx_o(rd_idx),
        .ram_rd_data_i(rd_data), .ram_wr_en_o(eng_we), .ram_wr_idx_o(eng_widx),
        .ram_wr_data_o(eng_wdata), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i), .done_o(ch_done_o),
        .busy_o(busy), .act_ch_o(act_ch)
    );

    // the channel in the engine, or the one about to be read from the RAM
    assign lock_ch        = busy ? act_ch : pick;
    assign cpu_wr_ready_o = !eng_we && !((busy || req_any) && (cpu_ch_i == lock_ch));

    always_comb begin
        cpu_ctx.src = cpu_src_i;
        cpu_ctx.dst = cpu_dst_i;
        cpu_ctx.cnt = cpu_cnt_i;
        cpu_ctx.ptr = cpu_ptr_i;
        ram_we      = eng_we || (cpu_wr_valid_i && cpu_wr_ready_o);
        ram_widx    = eng_we ? eng_widx  : cpu_ch_i;
        ram_wdata   = eng_we ? eng_wdata : cpu_ctx;
    end

    dma_ctx_ram #(.NCH(NCH)) i_ram (
        .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en), .rd_idx_i(rd_idx),
        .rd_data_o(rd_data), .wr_en_i(ram_we), .wr_idx_i(ram_widx),
        .wr_data_i(ram_wdata)
    );

    a_r8_cpu_locked_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && cpu_ch_i == act_ch) |-> !cpu_wr_ready_o);
    a_r8_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eng_we |-> !cpu_wr_ready_o);
endmodule

// File: tb/test_dma_swap_top.sv
module test_dma_swap_top;
    import dma_swap_pkg::*;
    localparam int NCH = 4;
    localparam int BURST = 4;
    localparam int CHW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] chan_req = '0;
    logic           cpu_valid = 1'b0, cpu_ready;
    logic [CHW-1:0] cpu_ch = '0;
    logic [AW-1:0]  cpu_src = '0, cpu_dst = '0, cpu_ptr = '0;
    logic [CW-1:0]  cpu_cnt = '0;
    logic           mem_req, mem_we, mem_ack;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;
    logic [NCH-1:0] done;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_swap_top #(.NCH(NCH), .BURST(BURST)) i_dma_swap_top (
        .clk_i(clk), .rst_ni(rst_n), .chan_req_i(chan_req),
        .cpu_wr_valid_i(cpu_valid), .cpu_wr_ready_o(cpu_ready), .cpu_ch_i(cpu_ch),
        .cpu_src_i(cpu_src), .cpu_dst_i(cpu_dst), .cpu_cnt_i(cpu_cnt),
        .cpu_ptr_i(cpu_ptr), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_ack_i(mem_ack), .ch_done_o(done)
    );

    // memory model plus bus monitor
    logic [31:0] mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_widx = '0;
    logic [31:0] tb_wdat = '0;
    logic [AW-1:0] wlog [64];
    int          wn = 0, reqcyc = 0, donecnt = 0, hold_viol = 0;
    logic        log_clr = 1'b0;
    logic        prev_wait = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 + i;
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            prev_wait <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (tb_we) mem[tb_widx] <= tb_wdat;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                mem_rdata <= mem[mem_addr[9:2]];
            end
            if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
            prev_wait <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
        end
        if (log_clr) begin
            wn <= 0; reqcyc <= 0; donecnt <= 0;
        end else if (rst_n) begin
            if (mem_req && mem_we && mem_ack && wn < 64) begin
                wlog[wn] <= mem_addr;
                wn <= wn + 1;
            end
            if (mem_req) reqcyc <= reqcyc + 1;
            if (done != '0) donecnt <= donecnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(input int ch, input int src, input int dst, input int cnt, input int ptr);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_ch = CHW'(ch);
        cpu_src = AW'(src); cpu_dst = AW'(dst); cpu_cnt = CW'(cnt); cpu_ptr = AW'(ptr);
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic mem_put(input int addr, input int data);
        @(negedge clk);
        tb_we = 1'b1; tb_widx = 8'(addr >> 2); tb_wdat = data;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    // waits for a done pulse on ch; returns pulses seen on that channel
    task automatic wait_done(input int ch, input int lim, output int seen);
        seen = 0;
        for (int c = 0; c < lim && seen == 0; c++) begin
            @(negedge clk);
            if (done[ch]) seen++;
        end
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (done[ch]) seen++;
        end
    endtask

    function automatic int copy_errs(input int src, input int dst, input int words);
        int e = 0;
        for (int i = 0; i < words; i++)
            if (mem[(dst >> 2) + i] != 32'hA500_0000 + (src >> 2) + i) e++;
        return e;
    endfunction

    // table: channel, source, destination, byte count
    localparam int TV [4][4] = '{
        '{3, 'h000, 'h300, 4},
        '{1, 'h040, 'h340, 12},
        '{2, 'h080, 'h380, 20},
        '{0, 'h0C0, 'h3C0, 16}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seen, e, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(mem_req == 1'b0, "R11 mem_req after reset", mem_req, 0);
        check(done == '0, "R11 done after reset", done, 0);
        check(cpu_ready == 1'b1, "R11 ready after reset", cpu_ready, 1);

        // R5 + R4 + R1: three channels requesting together, 8 words each
        for (int c = 0; c < 3; c++) prog(c, 'h040 * c, 'h200 + 'h40 * c, 32, 0);
        clear_log();
        @(negedge clk); chan_req = 4'b0111;
        for (int c = 0; c < 2000 && wn < 24; c++) @(negedge clk);
        chan_req = '0;
        repeat (20) @(negedge clk);
        bad = 0;
        for (int p = 0; p < 24; p++)
            if (int'((wlog[p] - 'h200) >> 6) != (p / BURST) % 3) bad++;
        check(wn == 24 && bad == 0, "R5 R4 R1 round-robin burst order", bad, 0);
        e = 0;
        for (int c = 0; c < 3; c++) e += copy_errs('h040 * c, 'h200 + 'h40 * c, 8);
        check(e == 0, "R3 interleaved copies intact", e, 0);
        check(donecnt == 3, "R7 one done per channel", donecnt, 3);
        check(hold_viol == 0, "R10 request held until ack", hold_viol, 0);

        // table of single-channel transfers (R2, R3, R7)
        foreach (TV[v]) begin
            prog(TV[v][0], TV[v][1], TV[v][2], TV[v][3], 0);
            @(negedge clk); chan_req[TV[v][0]] = 1'b1;
            wait_done(TV[v][0], 400, seen);
            chan_req = '0;
            e = copy_errs(TV[v][1], TV[v][2], TV[v][3] / 4);
            check(e == 0, "R2 R3 table copy", e, 0);
            check(seen == 1, "R7 table single done pulse", seen, 1);
        end

        // R9: zero count moves nothing, no done
        prog(3, 'h000, 'h100, 0, 0);
        clear_log();
        @(negedge clk); chan_req[3] = 1'b1;
        repeat (30) @(negedge clk);
        chan_req = '0;
        check(reqcyc == 0, "R9 zero count bus idle", reqcyc, 0);
        check(donecnt == 0, "R9 zero count no done", donecnt, 0);

        // R6: chained descriptor
        mem_put('h1F0, 'h120);
        mem_put('h1F4, 'h2E0);
        mem_put('h1F8, 8);
        mem_put('h1FC, 0);
        prog(2, 'h100, 'h2C0, 8, 'h1F0);
        clear_log();
        @(negedge clk); chan_req[2] = 1'b1;
        wait_done(2, 600, seen);
        chan_req = '0;
        check(copy_errs('h100, 'h2C0, 2) == 0, "R6 first segment", copy_errs('h100, 'h2C0, 2), 0);
        check(copy_errs('h120, 'h2E0, 2) == 0, "R6 linked segment", copy_errs('h120, 'h2E0, 2), 0);
        check(seen == 1 && donecnt == 1, "R7 chain done once at end", donecnt, 1);

        // R8: CPU lock on the loaded channel
        prog(1, 'h140, 'h200, 32, 0);
        @(negedge clk); chan_req[1] = 1'b1; cpu_ch = 2'd1;
        for (int c = 0; c < 200 && !(mem_req && !mem_we && mem_addr >= 'h140 && mem_addr < 'h160); c++)
            @(negedge clk);
        check(cpu_ready == 1'b0, "R8 locked channel ready low", cpu_ready, 0);
        cpu_ch = 2'd2;
        #1;
        check(cpu_ready == 1'b1, "R8 other channel ready high", cpu_ready, 1);
        wait_done(1, 600, seen);
        chan_req = '0;
        check(copy_errs('h140, 'h200, 8) == 0 && seen == 1, "R8 locked transfer completes", seen, 1);
        check(hold_viol == 0, "R10 no request change before ack", hold_viol, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule